// File: doc/BRIEF.md
# Floating-Point Compare and Sign-Move Unit

This block compares two IEEE-754 operands, either single or double precision as picked by a per-operation select. It turns the outcome into a 2-bit condition code and writes that code into bits [11:10] of a status word. The other bits of the word pass through unchanged from the status value presented with the operation. It also raises a one-cycle invalid-operation flag. The flag follows the quiet or signalling compare rules, so a signalling compare treats any unordered result as invalid, while a quiet compare objects only to a signalling NaN.

A second path, independent of the first, takes a raw 32-bit word and copies it, clears its sign bit, or flips its sign bit. This path never raises a flag. Each path has its own valid strobe and its own registered result. A compare and a sign move may therefore be issued in the same clock cycle.

Top module: `fp_cmp_cc_unit`

## Requirements
- R1: For ordered operands the condition code is 0 when A equals B, 1 when A is less than B and 2 when A is greater than B, with infinities ordered as the largest magnitudes.
- R2: With cmpDouble=1 all 64 bits of each operand take part (sign bit 63, exponent [62:52], fraction [51:0]). With cmpDouble=0 only bits [31:0] are used (sign 31, exponent [30:23], fraction [22:0]) and bits [63:32] have no effect.
- R3: A NaN has an all-ones exponent and a non-zero fraction. If either operand is a NaN the condition code is 3 (unordered).
- R4: A signalling compare (cmpSignal=1) with an unordered result sets invFlag.
- R5: A quiet compare (cmpSignal=0) with an unordered result sets invFlag only when at least one operand is a signalling NaN, that is a NaN whose fraction MSB is 0.
- R6: Positive and negative zero compare equal, and an ordered compare never sets invFlag.
- R7: In the cycle after cmpValid, statusOut equals the statusIn given with the compare, except that bits [11:10] hold the condition code. Without cmpValid, statusOut keeps its value. invFlag is high only in the cycle after a compare that raised it.
- R8: In the cycle after movValid, movResult holds movWord changed by movOp: 0 copies the word, 1 clears bit 31, 2 inverts bit 31, and 3 copies the word. movDone is high for exactly that cycle, and movResult holds its value otherwise.
- R9: While rstN is low, statusOut, invFlag, movResult and movDone are all zero.
- R10: A compare and a sign move issued in the same cycle both complete in the next cycle, and each gives the result it would give on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpValid | input | 1 | Start a compare this cycle |
| cmpSignal | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| cmpDouble | input | 1 | 1 selects double precision, 0 single precision |
| cmpA | input | 64 | First operand |
| cmpB | input | 64 | Second operand |
| statusIn | input | 32 | Status word that the condition code is merged into |
| statusOut | output | 32 | Registered status word carrying the condition code |
| invFlag | output | 1 | Invalid-operation pulse |
| movValid | input | 1 | Start a sign move this cycle |
| movOp | input | 2 | Move operation select |
| movWord | input | 32 | Raw word to move |
| movResult | output | 32 | Registered move result |
| movDone | output | 1 | Move result pulse |

## Verification
The compare write and the sign move can land in the same cycle, because each path has its own strobe and its own result register. The bench raises both strobes together in directed cases, using a sign-flip move together with an unordered signalling compare. It also raises both together in many random cycles, where each strobe is drawn independently. In every such cycle the merged status word, the invalid pulse and the move word are each checked against a bench model, and that model computes each path as if the other were not active.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } ccCode_t;

  typedef enum logic [1:0] {
    MV_COPY = 2'd0,
    MV_ABS  = 2'd1,
    MV_NEG  = 2'd2,
    MV_RSVD = 2'd3
  } movOp_t;

  typedef struct packed {
    logic ccWe;
    logic invRaise;
    logic movWe;
    logic clrSign;
    logic flipSign;
  } strobes_t;
endpackage

// File: rtl/fpcc_operand.sv
module fpcc_operand #(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52
) (
  input  logic                         isDouble,
  input  logic [DBL_EXP+DBL_FRAC:0]    word,
  output logic                         sign,
  output logic                         isNan,
  output logic                         isSnan,
  output logic                         isZero,
  output logic [DBL_EXP+DBL_FRAC-1:0]  mag
);
  localparam int SglW = 1 + SGL_EXP + SGL_FRAC;
  localparam int DblW = 1 + DBL_EXP + DBL_FRAC;

  logic expAllOnes, fracNonZero, fracTop;

  always_comb begin
    mag = '0;
    if (isDouble) begin
      sign        = word[DblW-1];
      expAllOnes  = &word[DblW-2:DBL_FRAC];
      fracNonZero = |word[DBL_FRAC-1:0];
      fracTop     = word[DBL_FRAC-1];
      mag         = word[DblW-2:0];
    end else begin
      sign        = word[SglW-1];
      expAllOnes  = &word[SglW-2:SGL_FRAC];
      fracNonZero = |word[SGL_FRAC-1:0];
      fracTop     = word[SGL_FRAC-1];
      mag[SglW-2:0] = word[SglW-2:0];
    end
    isNan  = expAllOnes & fracNonZero;
    isSnan = isNan & ~fracTop;
    isZero = (mag == '0);
  end
endmodule

// File: rtl/fpcc_ctrl.sv
module fpcc_ctrl
  import fpcc_pkg::*;
(
  input  logic     cmpValid,
  input  logic     cmpSignal,
  input  logic     unordered,
  input  logic     anySnan,
  input  logic     movValid,
  input  logic [1:0] movOp,
  output strobes_t strb
);
  movOp_t opSel;

  always_comb begin
    opSel         = movOp_t'(movOp);
    strb          = '0;
    strb.ccWe     = cmpValid;
    strb.invRaise = cmpValid & unordered & (cmpSignal | anySnan);
    strb.movWe    = movValid;
    strb.clrSign  = movValid & (opSel == MV_ABS);
    strb.flipSign = movValid & (opSel == MV_NEG);
  end
endmodule

// File: rtl/fpcc_datapath.sv
module fpcc_datapath
  import fpcc_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobes_t                     strb,
  input  logic                         cmpSignal,
  input  logic                         cmpDouble,
  input  logic [DBL_EXP+DBL_FRAC:0]    cmpA,
  input  logic [DBL_EXP+DBL_FRAC:0]    cmpB,
  input  logic [STATUS_W-1:0]          statusIn,
  input  logic [SGL_EXP+SGL_FRAC:0]    movWord,
  output logic                         unordered,
  output logic                         anySnan,
  output logic [STATUS_W-1:0]          statusOut,
  output logic                         invFlag,
  output logic [SGL_EXP+SGL_FRAC:0]    movResult,
  output logic                         movDone
);
  localparam int DblW = 1 + DBL_EXP + DBL_FRAC;
  localparam int SglW = 1 + SGL_EXP + SGL_FRAC;
  localparam int NumOps = 2;

  logic [DblW-1:0] opWord [NumOps];
  logic            opSign [NumOps];
  logic            opNan  [NumOps];
  logic            opSnan [NumOps];
  logic            opZero [NumOps];
  logic [DblW-2:0] opMag  [NumOps];

  assign opWord[0] = cmpA;
  assign opWord[1] = cmpB;

  for (genvar g = 0; g < NumOps; g++) begin : g_cls
    fpcc_operand #(
      .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC),
      .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC)
    ) u_cls (
      .isDouble(cmpDouble),
      .word    (opWord[g]),
      .sign    (opSign[g]),
      .isNan   (opNan[g]),
      .isSnan  (opSnan[g]),
      .isZero  (opZero[g]),
      .mag     (opMag[g])
    );
  end

  ccCode_t ccNext;
  logic    aSmaller;
  logic    aLess;

  always_comb begin
    unordered = opNan[0] | opNan[1];
    anySnan   = opSnan[0] | opSnan[1];
    aSmaller  = opMag[0] < opMag[1];
    aLess     = opSign[0] ? ~aSmaller : aSmaller;
    if (unordered)                              ccNext = CC_UN;
    else if (opZero[0] && opZero[1])            ccNext = CC_EQ;
    else if (opSign[0] != opSign[1])            ccNext = opSign[0] ? CC_LT : CC_GT;
    else if (opMag[0] == opMag[1])              ccNext = CC_EQ;
    else                                        ccNext = aLess ? CC_LT : CC_GT;
  end

  logic [SglW-1:0] movNext;
  always_comb begin
    movNext = movWord;
    if (strb.clrSign)  movNext[SglW-1] = 1'b0;
    if (strb.flipSign) movNext[SglW-1] = ~movWord[SglW-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOut <= '0;
      invFlag   <= 1'b0;
      movResult <= '0;
      movDone   <= 1'b0;
    end else begin
      invFlag <= strb.invRaise;
      movDone <= strb.movWe;
      if (strb.ccWe) begin
        statusOut <= statusIn;
        statusOut[CC_LSB+1:CC_LSB] <= ccNext;
      end
      if (strb.movWe) movResult <= movNext;
    end
  end

  a_r4_sig_unord_inv: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ccWe && cmpSignal && unordered) |=> invFlag);
  a_r5_quiet_qnan_no_inv: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ccWe && !cmpSignal && !anySnan) |=> !invFlag);
  a_r6_ordered_no_inv: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ccWe && ccNext != CC_UN) |=> !invFlag);
  a_r7_cc_written: assert property (@(posedge clk) disable iff (!rstN)
    strb.ccWe |=> statusOut[CC_LSB+1:CC_LSB] == $past(ccNext));
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ccWe |=> $stable(statusOut));
  a_r8_move_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.movWe |=> ($stable(movResult) && !movDone));
  a_r8_abs_sign: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrSign |=> !movResult[SglW-1]);
  a_r3_nan_unord: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ccWe && unordered) |=> statusOut[CC_LSB+1:CC_LSB] == 2'd3);
endmodule

// File: rtl/fp_cmp_cc_unit.sv
module fp_cmp_cc_unit
  import fpcc_pkg::*;
#(
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23,
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int STATUS_W = 32,
  parameter int CC_LSB   = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmpValid,
  input  logic                      cmpSignal,
  input  logic                      cmpDouble,
  input  logic [DBL_EXP+DBL_FRAC:0] cmpA,
  input  logic [DBL_EXP+DBL_FRAC:0] cmpB,
  input  logic [STATUS_W-1:0]       statusIn,
  output logic [STATUS_W-1:0]       statusOut,
  output logic                      invFlag,
  input  logic                      movValid,
  input  logic [1:0]                movOp,
  input  logic [SGL_EXP+SGL_FRAC:0] movWord,
  output logic [SGL_EXP+SGL_FRAC:0] movResult,
  output logic                      movDone
);
  strobes_t strb;
  logic     unordered, anySnan;

  fpcc_ctrl u_ctrl (
    .cmpValid (cmpValid),
    .cmpSignal(cmpSignal),
    .unordered(unordered),
    .anySnan  (anySnan),
    .movValid (movValid),
    .movOp    (movOp),
    .strb     (strb)
  );

  fpcc_datapath #(
    .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC),
    .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC),
    .STATUS_W(STATUS_W), .CC_LSB(CC_LSB)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmpSignal(cmpSignal),
    .cmpDouble(cmpDouble),
    .cmpA     (cmpA),
    .cmpB     (cmpB),
    .statusIn (statusIn),
    .movWord  (movWord),
    .unordered(unordered),
    .anySnan  (anySnan),
    .statusOut(statusOut),
    .invFlag  (invFlag),
    .movResult(movResult),
    .movDone  (movDone)
  );
endmodule

// File: tb/test_fp_cmp_cc_unit.sv
module test_fp_cmp_cc_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmpValid, cmpSignal, cmpDouble;
  logic [63:0] cmpA, cmpB;
  logic [31:0] statusIn, statusOut;
  logic        invFlag;
  logic        movValid;
  logic [1:0]  movOp;
  logic [31:0] movWord, movResult;
  logic        movDone;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] expStatus;
  logic [31:0] expMov;

  always #10 clk = ~clk;

  fp_cmp_cc_unit i_fp_cmp_cc_unit (
    .clk(clk), .rstN(rstN),
    .cmpValid(cmpValid), .cmpSignal(cmpSignal), .cmpDouble(cmpDouble),
    .cmpA(cmpA), .cmpB(cmpB), .statusIn(statusIn),
    .statusOut(statusOut), .invFlag(invFlag),
    .movValid(movValid), .movOp(movOp), .movWord(movWord),
    .movResult(movResult), .movDone(movDone)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit isNanF(logic [63:0] w, bit dbl);
    if (dbl) return (w[62:52] == 11'h7ff) && (w[51:0] != 0);
    return (w[30:23] == 8'hff) && (w[22:0] != 0);
  endfunction

  function automatic bit isSnanF(logic [63:0] w, bit dbl);
    if (dbl) return isNanF(w, dbl) && !w[51];
    return isNanF(w, dbl) && !w[22];
  endfunction

  function automatic logic signed [64:0] keyF(logic [63:0] w, bit dbl);
    logic signed [64:0] m;
    bit s;
    if (dbl) begin m = {2'b00, w[62:0]}; s = w[63]; end
    else begin m = {34'd0, w[30:0]}; s = w[31]; end
    return s ? -m : m;
  endfunction

  function automatic logic [1:0] expCc(logic [63:0] a, logic [63:0] b, bit dbl);
    if (isNanF(a, dbl) || isNanF(b, dbl)) return 2'd3;
    if (keyF(a, dbl) == keyF(b, dbl)) return 2'd0;
    if (keyF(a, dbl) < keyF(b, dbl)) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [63:0] genVal(bit dbl);
    int k = $urandom_range(0, 6);
    logic [63:0] r = {$urandom, $urandom};
    logic [63:0] v;
    if (dbl) begin
      case (k)
        0: v = {r[63], 63'd0};
        1: v = {r[63], 11'h7ff, 52'd0};
        2: v = {r[63], 11'h7ff, 1'b1, r[50:0]};
        3: v = {r[63], 11'h7ff, 1'b0, r[50:1], 1'b1};
        4: v = {r[63], 11'h3ff, r[51:48], 48'd0};
        default: v = r;
      endcase
    end else begin
      case (k)
        0: v = {r[63:32], r[31], 31'd0};
        1: v = {r[63:32], r[31], 8'hff, 23'd0};
        2: v = {r[63:32], r[31], 8'hff, 1'b1, r[21:0]};
        3: v = {r[63:32], r[31], 8'hff, 1'b0, r[21:1], 1'b1};
        4: v = {r[63:32], r[31], 8'h7f, r[22:20], 20'd0};
        default: v = r;
      endcase
    end
    return v;
  endfunction

  // Drive at a negedge, clock once, check at the next negedge.
  task automatic runOp(input bit cv, input bit sig, input bit dbl,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] sIn, input bit mv,
                       input logic [1:0] mop, input logic [31:0] mw,
                       input string tag);
    logic [1:0] cc;
    bit expInv;
    string ccReq, invReq;
    cmpValid = cv; cmpSignal = sig; cmpDouble = dbl; cmpA = a; cmpB = b;
    statusIn = sIn; movValid = mv; movOp = mop; movWord = mw;
    cc = expCc(a, b, dbl);
    expInv = cv && (cc == 2'd3) && (sig || isSnanF(a, dbl) || isSnanF(b, dbl));
    if (cv) begin
      expStatus = sIn;
      expStatus[11:10] = cc;
    end
    if (mv) begin
      expMov = mw;
      if (mop == 2'd1) expMov[31] = 1'b0;
      if (mop == 2'd2) expMov[31] = ~mw[31];
    end
    @(posedge clk);
    @(negedge clk);
    cmpValid = 1'b0; movValid = 1'b0;
    if (cc == 2'd3) ccReq = "R3";
    else if (dbl) ccReq = "R2";
    else if (keyF(a, dbl) == 0 && keyF(b, dbl) == 0) ccReq = "R6";
    else ccReq = "R1";
    if (cc != 2'd3) invReq = "R6";
    else invReq = sig ? "R4" : "R5";
    if (tag.len() != 0) begin ccReq = tag; invReq = tag; end
    chk({ccReq, " cc"}, {62'd0, statusOut[11:10]}, {62'd0, expStatus[11:10]});
    chk({"R7 status"}, {32'd0, statusOut}, {32'd0, expStatus});
    chk({invReq, " inv"}, {63'd0, invFlag}, {63'd0, expInv});
    chk({(tag.len() != 0) ? tag : "R8", " mov"}, {32'd0, movResult}, {32'd0, expMov});
    chk("R8 done", {63'd0, movDone}, {63'd0, mv});
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    cmpValid = 0; cmpSignal = 0; cmpDouble = 0; cmpA = 0; cmpB = 0;
    statusIn = 0; movValid = 0; movOp = 0; movWord = 0;
    expStatus = 0; expMov = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 status", {32'd0, statusOut}, 64'd0);
    chk("R9 inv", {63'd0, invFlag}, 64'd0);
    chk("R9 mov", {32'd0, movResult}, 64'd0);
    chk("R9 done", {63'd0, movDone}, 64'd0);
    rstN = 1'b1;

    // R1 single ordered
    runOp(1, 0, 0, 64'h3f800000, 64'h40000000, 32'hffffffff, 0, 0, 0, "R1");
    runOp(1, 0, 0, 64'hbf800000, 64'hc0000000, 32'h00000000, 0, 0, 0, "R1");
    runOp(1, 0, 0, 64'h7f800000, 64'h7f7fffff, 32'h12345678, 0, 0, 0, "R1");
    // R6 zeros
    runOp(1, 1, 0, 64'h00000000, 64'h80000000, 32'h00000c00, 0, 0, 0, "R6");
    // R2 single ignores upper bits; double uses them
    runOp(1, 0, 0, 64'h12345678_3f800000, 64'h9abcdef0_3f800000, 32'h0, 0, 0, 0, "R2");
    runOp(1, 0, 1, 64'h3ff00000_00000000, 64'h40000000_00000000, 32'h0, 0, 0, 0, "R2");
    runOp(1, 0, 1, 64'hc0000000_00000000, 64'hbff00000_00000000, 32'h0, 0, 0, 0, "R2");
    // R3/R5 quiet NaN quiet compare: no invalid
    runOp(1, 0, 0, 64'h7fc00000, 64'h3f800000, 32'h0, 0, 0, 0, "R5");
    // R5 signalling NaN quiet compare: invalid
    runOp(1, 0, 0, 64'h3f800000, 64'h7f800001, 32'h0, 0, 0, 0, "R5");
    runOp(1, 0, 1, 64'h7ff00000_00000001, 64'h0, 32'h0, 0, 0, 0, "R5");
    // R4 quiet NaN signalling compare: invalid
    runOp(1, 1, 1, 64'h0, 64'hfff80000_00000000, 32'h0, 0, 0, 0, "R4");
    // R7 hold with no compare
    runOp(0, 0, 0, 64'h0, 64'h0, 32'hdeadbeef, 0, 0, 0, "R7");
    // R8 moves
    runOp(0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h8000_1234, "R8");
    runOp(0, 0, 0, 0, 0, 0, 1, 2'd1, 32'hc000_0001, "R8");
    runOp(0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h4000_0001, "R8");
    runOp(0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hffff_ffff, "R8");
    // R10 both paths in one cycle
    runOp(1, 1, 0, 64'h7fc00000, 64'h0, 32'h0000_0400, 1, 2'd2, 32'h8765_4321, "R10");
    runOp(1, 0, 1, 64'h3ff00000_00000000, 64'h3ff00000_00000000, 32'ha5a5a5a5, 1, 2'd1, 32'h8000_0000, "R10");

    for (int i = 0; i < 3000; i++) begin
      bit dbl = $urandom_range(0, 1) == 1;
      logic [63:0] a = genVal(dbl);
      logic [63:0] b = ($urandom_range(0, 7) == 0) ? a : genVal(dbl);
      runOp($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, dbl, a, b,
            $urandom, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
            $urandom, "");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule